// File: doc/BRIEF.md
# Sensor Interrupt Line Controller

This block produces a sensor's interrupt pin from four internal event strobes: new sample data, engine completion, device ready (clock lock after a source change) and an auxiliary bus master error. Each strobe sets its own sticky status bit. The pin is asserted from the status bits whose enable is set. A single 8-bit configuration byte selects, while the device runs, the pin's active level, its drive type (push-pull, or open drain that only pulls low), whether the pin holds a level or emits a fixed-length pulse, and which register reads clear the status.

The block sits on a simple register port shared with the rest of the device. It answers reads of its configuration and status registers, accepts writes to its configuration register and sees every read on that port, because one clearing mode clears status on a read of any address. Pulse length is set in clock cycles, derived from the clock frequency and a duration in microseconds.

Top module: `sirq_top`

## Requirements
- R1: After reset the configuration byte reads 0x00, all status bits are clear, and the pad is driven low with output enable high (push-pull, active high, idle).
- R2: A write to address 0x17 loads the configuration byte on the next clock edge, and a read of 0x17 returns it. The bit positions are: [7] active low, [6] open drain, [5] latched, [4] any read clears, [3] aux error enable, [2] ready enable, [1] done enable, [0] data enable.
- R3: In push-pull mode (bit 6 = 0) the output enable is always 1. The pad equals the internal assert when bit 7 = 0 and its inverse when bit 7 = 1.
- R4: In open-drain mode (bit 6 = 1) the pad data is always 0 and the output enable equals the internal assert, whatever bit 7 holds.
- R5: In latched mode (bit 5 = 1) the assert is high from the cycle after an enabled event until the cycle after a clearing read.
- R6: In pulse mode (bit 5 = 0) an enabled event asserts for exactly PULSE_CYC cycles starting the cycle after it. A new enabled event during a pulse restarts the full count.
- R7: With bit 4 = 0 only a read of address 0x1A clears status. Reads of other addresses leave status unchanged.
- R8: With bit 4 = 1 a read of any address clears status.
- R9: An event arriving in the same cycle as a clearing read leaves its status bit set.
- R10: A source whose enable is 0 still sets its status bit but does not assert the pin. Clearing an enable does not clear the status bit.
- R11: A read of 0x1A returns status ANDed with enables in bits [3:0] (data, done, ready, aux error) and zeros in [7:4]. Writes to 0x1A have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 4 | Event strobes: [0] data, [1] done, [2] ready, [3] aux error |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational, zero when not reading |
| irqPadOut | output | 1 | Pad data |
| irqPadOe | output | 1 | Pad output enable |

## Verification
The assertions assume the event strobes and register strobes are synchronous to the clock and hold known values from reset onward. They also assume that a configuration write takes effect only at the clock edge, so the drive-mode properties judge the pad against the byte currently held. The stimulus changes every input only at the falling edge and holds it for one full cycle. It strobes events and reads for single cycles or deliberate overlaps, so each sticky, clear and retrigger case is reached without undefined values.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NUM_SRC = 4;

  // Field order is the register layout, MSB first.
  typedef struct packed {
    logic               actLow;
    logic               openDrain;
    logic               latchMode;
    logic               anyRdClr;
    logic [NUM_SRC-1:0] srcEn;
  } cfg_t;

  typedef struct packed {
    logic               clrStatus;
    logic               latchMode;
    logic               actLow;
    logic               openDrain;
    logic [NUM_SRC-1:0] srcEn;
  } strobe_t;
endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h17,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1A
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [$bits(cfg_t)-1:0] regWrData,
  input  logic [NUM_SRC-1:0]     statBits,
  output logic [$bits(cfg_t)-1:0] regRdData,
  output logic [$bits(cfg_t)-1:0] cfgByte,
  output strobe_t                strb
);
  localparam int DATA_W = $bits(cfg_t);

  cfg_t cfgQ;
  logic cfgHit;
  logic statHit;

  assign cfgHit  = (regAddr == CFG_ADDR);
  assign statHit = (regAddr == STAT_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWrEn && cfgHit) begin
      cfgQ <= cfg_t'(regWrData);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      if (cfgHit) begin
        regRdData = cfgQ;
      end else if (statHit) begin
        regRdData = DATA_W'(statBits & cfgQ.srcEn);
      end
    end
  end

  always_comb begin
    strb.clrStatus = regRdEn && (statHit || cfgQ.anyRdClr);
    strb.latchMode = cfgQ.latchMode;
    strb.actLow    = cfgQ.actLow;
    strb.openDrain = cfgQ.openDrain;
    strb.srcEn     = cfgQ.srcEn;
  end

  assign cfgByte = cfgQ;
endmodule

// File: rtl/sirq_dp.sv
module sirq_dp
  import sirq_pkg::*;
#(
  parameter int PULSE_CYC = 12500
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  strobe_t            strb,
  output logic [NUM_SRC-1:0] statBits,
  output logic               padOut,
  output logic               padOe
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [NUM_SRC-1:0] statQ;
  logic [CNT_W-1:0]   pulseCnt;
  logic               pulseTrig;
  logic               irqActive;

  // Status bits: a clearing read and a new event may coincide; the event stays.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ <= (strb.clrStatus ? '0 : statQ) | evtIn;
    end
  end

  assign pulseTrig = |(evtIn & strb.srcEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (pulseTrig) begin
      pulseCnt <= CNT_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    if (strb.latchMode) begin
      irqActive = |(statQ & strb.srcEn);
    end else begin
      irqActive = (pulseCnt != '0);
    end
  end

  always_comb begin
    if (strb.openDrain) begin
      padOut = 1'b0;
      padOe  = irqActive;
    end else begin
      padOut = irqActive ^ strb.actLow;
      padOe  = 1'b1;
    end
  end

  assign statBits = statQ;
endmodule

// File: rtl/sirq_top.sv
module sirq_top
  import sirq_pkg::*;
#(
  parameter int   CLK_HZ   = 250_000_000,
  parameter int   PULSE_US = 50,
  parameter int   ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h17,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        evtIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irqPadOut,
  output logic              irqPadOe
);
  localparam int PULSE_RAW = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

  strobe_t            strb;
  logic [7:0]         cfgByte;
  logic [NUM_SRC-1:0] statBits;

  sirq_ctrl #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .statBits(statBits),
    .regRdData(regRdData), .cfgByte(cfgByte), .strb(strb)
  );

  sirq_dp #(
    .PULSE_CYC(PULSE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb),
    .statBits(statBits), .padOut(irqPadOut), .padOe(irqPadOe)
  );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h17,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1A
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        evtIn,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              irqPadOut,
  input logic              irqPadOe,
  input logic [7:0]        cfgByte,
  input logic [3:0]        statBits
);
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CFG_ADDR) |=> (cfgByte == $past(regWrData)));

  a_r3_pushpull_oe: assert property (@(posedge clk) disable iff (!rstN)
    !cfgByte[6] |-> irqPadOe);

  a_r4_opendrain_low: assert property (@(posedge clk) disable iff (!rstN)
    cfgByte[6] |-> (irqPadOut == 1'b0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdEn || (regAddr != STAT_ADDR && !cfgByte[4]))
      |=> ((statBits & $past(statBits)) == $past(statBits)));

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((statBits & $past(evtIn)) == $past(evtIn)));

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == STAT_ADDR) |-> (regRdData[7:4] == 4'h0));
endmodule

bind sirq_top sirq_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
  .regRdData(regRdData), .irqPadOut(irqPadOut), .irqPadOe(irqPadOe),
  .cfgByte(cfgByte), .statBits(statBits)
);

// File: tb/sirq_top_test.sv
module sirq_top_test;
  localparam int PULSE = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] evtIn = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqPadOut;
  logic       irqPadOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] mCfg = '0;
  logic [3:0] mStat = '0;
  int         mRem = 0;

  always #2 clk = ~clk;

  sirq_top #(.CLK_HZ(1_000_000), .PULSE_US(PULSE)) uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqPadOut(irqPadOut), .irqPadOe(irqPadOe)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkPad(input string tag);
    bit act;
    act = mCfg[5] ? |(mStat & mCfg[3:0]) : (mRem > 0);
    if (mCfg[6]) begin
      check(tag, "padOut", irqPadOut, 0);
      check(tag, "padOe", irqPadOe, act);
    end else begin
      check(tag, "padOut", irqPadOut, mCfg[7] ? !act : act);
      check(tag, "padOe", irqPadOe, 1);
    end
  endtask

  // One cycle: drive at falling edge, check read data, model the edge, check pad.
  task automatic cyc(input string tag, input logic [3:0] ev, input bit wr, input bit rd,
                     input logic [7:0] addr, input logic [7:0] wd);
    logic [7:0] expRd;
    bit clr;
    evtIn = ev; regWrEn = wr; regRdEn = rd; regAddr = addr; regWrData = wd;
    #1;
    expRd = 8'h00;
    if (rd && addr == 8'h17) expRd = mCfg;
    else if (rd && addr == 8'h1A) expRd = {4'h0, mStat & mCfg[3:0]};
    if (rd) check(tag, "regRdData", regRdData, expRd);
    @(posedge clk);
    clr = rd && (addr == 8'h1A || mCfg[4]);
    if ((ev & mCfg[3:0]) != 0) mRem = PULSE;
    else if (mRem > 0) mRem--;
    mStat = (clr ? 4'h0 : mStat) | ev;
    if (wr && addr == 8'h17) mCfg = wd;
    @(negedge clk);
    checkPad(tag);
    evtIn = '0; regWrEn = 0; regRdEn = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 4'h0, 0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "padOut", irqPadOut, 0);
    check("R1", "padOe", irqPadOe, 1);
    rstN = 1'b1;
    @(negedge clk);
    cyc("R1", 4'h0, 0, 1, 8'h17, 8'h00);
    cyc("R1", 4'h0, 0, 1, 8'h1A, 8'h00);

    // R2 + R5: latched, data enable
    cyc("R2", 4'h0, 1, 0, 8'h17, 8'h21);
    cyc("R2", 4'h0, 0, 1, 8'h17, 8'h00);
    cyc("R5", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R5", 4);
    // R7: other reads do not clear
    cyc("R7", 4'h0, 0, 1, 8'h17, 8'h00);
    cyc("R7", 4'h0, 0, 1, 8'h05, 8'h00);
    idle("R7", 2);
    // R11: status format, then clear by status read
    cyc("R11", 4'h0, 0, 1, 8'h1A, 8'h00);
    cyc("R11", 4'h0, 0, 1, 8'h1A, 8'h00);
    idle("R5", 2);

    // R10: disabled source sets status but no assert
    cyc("R10", 4'h2, 0, 0, 8'h00, 8'h00);
    idle("R10", 2);
    cyc("R10", 4'h0, 0, 1, 8'h1A, 8'h00);
    cyc("R10", 4'h0, 1, 0, 8'h17, 8'h23);
    idle("R10", 2);
    cyc("R10", 4'h0, 1, 0, 8'h17, 8'h21);
    cyc("R10", 4'h0, 1, 0, 8'h17, 8'h23);
    cyc("R10", 4'h0, 0, 1, 8'h1A, 8'h00);
    idle("R10", 2);

    // R8: any read clears
    cyc("R8", 4'h0, 1, 0, 8'h17, 8'h3F);
    cyc("R8", 4'h8, 0, 0, 8'h00, 8'h00);
    idle("R8", 2);
    cyc("R8", 4'h0, 0, 1, 8'h05, 8'h00);
    idle("R8", 2);

    // R9: event in the clearing cycle survives
    cyc("R9", 4'h0, 1, 0, 8'h17, 8'h25);
    cyc("R9", 4'h4, 0, 0, 8'h00, 8'h00);
    cyc("R9", 4'h4, 0, 1, 8'h1A, 8'h00);
    idle("R9", 2);
    cyc("R9", 4'h0, 0, 1, 8'h1A, 8'h00);
    idle("R9", 2);

    // R6: pulse mode and retrigger
    cyc("R6", 4'h0, 1, 0, 8'h17, 8'h01);
    cyc("R6", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R6", PULSE + 2);
    cyc("R6", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R6", 3);
    cyc("R6", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R6", PULSE + 2);
    cyc("R6", 4'h2, 0, 0, 8'h00, 8'h00);
    idle("R6", 2);

    // R3: active low push-pull
    cyc("R3", 4'h0, 1, 0, 8'h17, 8'h81);
    cyc("R3", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R3", PULSE + 2);

    // R4: open drain, both polarities
    cyc("R4", 4'h0, 1, 0, 8'h17, 8'h41);
    cyc("R4", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R4", PULSE + 2);
    cyc("R4", 4'h0, 1, 0, 8'h17, 8'hE1);
    cyc("R4", 4'h1, 0, 0, 8'h00, 8'h00);
    idle("R4", 3);
    cyc("R4", 4'h0, 0, 1, 8'h1A, 8'h00);
    idle("R4", 2);

    // R11: writes to status address ignored
    cyc("R11", 4'h0, 1, 0, 8'h17, 8'h2F);
    cyc("R11", 4'h0, 1, 0, 8'h1A, 8'hFF);
    cyc("R11", 4'h0, 0, 1, 8'h1A, 8'h00);
    cyc("R11", 4'h0, 0, 1, 8'h17, 8'h00);
    idle("R11", 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule